// File: doc/BRIEF.md
# USB Port Ownership Router

This block steers each physical port transceiver to exactly one of two kinds of port register sets: the set of the single high-speed controller, which has registers for every port, or the set of one full/low-speed companion controller. Each companion serves a fixed group of consecutive ports. Companion `c` serves ports `c*COMP_PORTS` up to `c*COMP_PORTS + COMP_PORTS - 1`. A companion register slot `s` belongs to port `s`. Ports at index `N_COMP*COMP_PORTS` and above have no companion and are always driven by the high-speed controller.

Ownership is decided at two levels. A global configured flag sets the policy. Per-port owner bits pick the owner port by port, and they take effect only while the flag is set. An owner bit of 1 means the companion owns the port, and 0 means the high-speed controller owns it. While the flag is clear, every port that has a companion belongs to that companion, so full and low speed keep working with no high-speed software present.

The transceiver's transmit data and control come from the owner. The transceiver's connect status and line state are passed only to the owner. The controller that does not own a port sees a port that is disconnected and idle. When ownership moves, the old owner sees a disconnect and the new owner sees the present connect state as a fresh change event.

Top module: `usb_port_route`

## Requirements
- R1: During reset and afterwards until the first owner change, `owner_o` reads 1 for every port that has a companion and 0 for the others, and all connect outputs are 0.
- R2: While `cfg_flag_i` is 0, owner writes are ignored and every port that has a companion reads as owner 1.
- R3: At the clock edge where `cfg_flag_i` is first sampled 1 after being 0, all owner bits become 0. A write presented in that same cycle is discarded.
- R4: While the flag is 1 and was 1 at the previous edge, a port with `own_wr_i` set takes `own_wdata_i` at the next edge. A port without a companion always reads 0.
- R5: `xcvr_tx_o` byte `p` equals `cc_tx_i` slot `p` when `owner_o[p]` is 1, and `hs_tx_i` byte `p` otherwise. It follows the owner bit combinationally.
- R6: One edge after an input is sampled, the owner's connect output equals the transceiver connect input and the non-owner's connect output is 0. Both are computed from the owner bits held before that edge.
- R7: The 2-bit line state of a port reaches only its owner, registered the same way as the connect output. The non-owner's line output is 0.
- R8: A connect-change output is 1 for exactly the one cycle after the matching connect output has changed, including changes caused by a move of ownership.
- R9: With `N_COMP` = 0, `owner_o` stays 0, every port is transmitted from `hs_tx_i`, and the high-speed connect outputs follow the transceivers.
- R10: At the edge where `cfg_flag_i` is sampled 0 after being 1, every port that has a companion returns to owner 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flag_i | input | 1 | Global configured flag (1 = high-speed software present) |
| own_wr_i | input | N_PORTS | Per-port owner write strobe |
| own_wdata_i | input | N_PORTS | Owner value to write (1 = companion) |
| owner_o | output | N_PORTS | Current owner bits |
| hs_tx_i | input | N_PORTS*DW | High-speed controller transmit data/control per port |
| cc_tx_i | input | CS*DW | Companion transmit data/control per slot |
| xcvr_tx_o | output | N_PORTS*DW | Data/control delivered to each transceiver |
| xcvr_conn_i | input | N_PORTS | Transceiver connect status |
| xcvr_line_i | input | N_PORTS*LW | Transceiver line state |
| hs_conn_o | output | N_PORTS | Connect status seen by the high-speed registers |
| hs_csc_o | output | N_PORTS | Connect-change pulse to the high-speed registers |
| hs_line_o | output | N_PORTS*LW | Line state seen by the high-speed registers |
| cc_conn_o | output | CS | Connect status seen by each companion slot |
| cc_csc_o | output | CS | Connect-change pulse to each companion slot |
| cc_line_o | output | CS*LW | Line state seen by each companion slot |

## Verification
The bench first tries to take ports away from the companions while the flag is still clear. A design that obeyed those writes would hand ports to a controller with no software behind it. It then raises the flag together with a pending write, which catches a design that lets the write win over the global clear. It checks the hand-over cycle by cycle: the old owner must see a disconnect pulse and the new owner a connect pulse one edge after the owner bits move. A design with no view register, or one that skipped the change pulse, would show the connect too early or never report it. The bench also checks the last port, which has no companion, and a second instance with no companions at all. A wrong slot map would route that port's data from a companion that does not exist.

// File: rtl/usb_route_pkg.sv
package usb_route_pkg;

  // a port has a companion when it falls inside the companion slot range
  function automatic logic port_served(input int p, input int nc, input int ppc);
    return (p < nc * ppc);
  endfunction

  // number of companion slots; one dummy slot when there are no companions
  function automatic int slot_count(input int nc, input int ppc);
    return (nc * ppc == 0) ? 1 : nc * ppc;
  endfunction

endpackage

// File: rtl/usb_own_ctl.sv
module usb_own_ctl #(
  parameter int N_PORTS    = 5,
  parameter int N_COMP     = 2,
  parameter int COMP_PORTS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_flag_i,
  input  logic [N_PORTS-1:0] own_wr_i,
  input  logic [N_PORTS-1:0] own_wdata_i,
  output logic [N_PORTS-1:0] own_o
);

  logic [N_PORTS-1:0] served_m;
  logic [N_PORTS-1:0] own_q;
  logic               flag_q;
  logic               flag_rise;
  logic [N_PORTS-1:0] wr_mask;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_srv
    assign served_m[p] = usb_route_pkg::port_served(p, N_COMP, COMP_PORTS);
  end

  assign flag_rise = cfg_flag_i && !flag_q;
  assign wr_mask   = own_wr_i & served_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= served_m;
      flag_q <= 1'b0;
    end else begin
      flag_q <= cfg_flag_i;
      if (!cfg_flag_i)
        own_q <= served_m;
      else if (flag_rise)
        own_q <= '0;
      else
        own_q <= (own_q & ~own_wr_i) | (own_wdata_i & wr_mask);
    end
  end

  assign own_o = own_q;

  // R2 / R10: a clear flag hands every served port to its companion
  a_r2_clear_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag_i |=> (own_o == served_m));

  a_r3_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rise |=> (own_o == '0));

  a_r4_unserved_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_o & ~served_m) == '0));

endmodule

// File: rtl/usb_conn_view.sv
module usb_conn_view #(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conn_i,
  input  logic [LW-1:0] line_i,
  input  logic          mine_i,
  output logic          conn_o,
  output logic          csc_o,
  output logic [LW-1:0] line_o
);

  logic          seen;
  logic          conn_edge;
  logic          conn_q;
  logic          csc_q;
  logic [LW-1:0] line_q;

  assign seen      = conn_i & mine_i;
  assign conn_edge = seen ^ conn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      csc_q  <= 1'b0;
      line_q <= '0;
    end else begin
      conn_q <= seen;
      csc_q  <= conn_edge;
      line_q <= mine_i ? line_i : '0;
    end
  end

  assign conn_o = conn_q;
  assign csc_o  = csc_q;
  assign line_o = line_q;

  a_r8_csc_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    csc_o |-> (conn_o != $past(conn_o)));

  a_r6_nonowner_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !mine_i |=> !conn_o);

  a_r7_line_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mine_i |=> (line_o == '0));

endmodule

// File: rtl/usb_port_route.sv
module usb_port_route #(
  parameter int  N_PORTS    = 5,
  parameter int  N_COMP     = 2,
  parameter int  COMP_PORTS = 2,
  parameter int  DW         = 8,
  parameter int  LW         = 2,
  localparam int CS         = usb_route_pkg::slot_count(N_COMP, COMP_PORTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_flag_i,
  input  logic [N_PORTS-1:0]    own_wr_i,
  input  logic [N_PORTS-1:0]    own_wdata_i,
  output logic [N_PORTS-1:0]    owner_o,
  input  logic [N_PORTS*DW-1:0] hs_tx_i,
  input  logic [CS*DW-1:0]      cc_tx_i,
  output logic [N_PORTS*DW-1:0] xcvr_tx_o,
  input  logic [N_PORTS-1:0]    xcvr_conn_i,
  input  logic [N_PORTS*LW-1:0] xcvr_line_i,
  output logic [N_PORTS-1:0]    hs_conn_o,
  output logic [N_PORTS-1:0]    hs_csc_o,
  output logic [N_PORTS*LW-1:0] hs_line_o,
  output logic [CS-1:0]         cc_conn_o,
  output logic [CS-1:0]         cc_csc_o,
  output logic [CS*LW-1:0]      cc_line_o
);

  localparam int SERVED = N_COMP * COMP_PORTS;

  logic [N_PORTS-1:0] own;

  usb_own_ctl #(.N_PORTS(N_PORTS), .N_COMP(N_COMP), .COMP_PORTS(COMP_PORTS)) u_own (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_flag_i (cfg_flag_i),
    .own_wr_i   (own_wr_i),
    .own_wdata_i(own_wdata_i),
    .own_o      (own)
  );

  assign owner_o = own;

  // per-port transmit mux and high-speed side view
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    if (p < SERVED) begin : g_mux
      assign xcvr_tx_o[p*DW +: DW] = own[p] ? cc_tx_i[p*DW +: DW] : hs_tx_i[p*DW +: DW];
    end else begin : g_hs_only
      assign xcvr_tx_o[p*DW +: DW] = hs_tx_i[p*DW +: DW];
    end

    usb_conn_view #(.LW(LW)) u_hs_view (
      .clk    (clk),
      .rst_n  (rst_n),
      .conn_i (xcvr_conn_i[p]),
      .line_i (xcvr_line_i[p*LW +: LW]),
      .mine_i (~own[p]),
      .conn_o (hs_conn_o[p]),
      .csc_o  (hs_csc_o[p]),
      .line_o (hs_line_o[p*LW +: LW])
    );
  end

  // companion side view, slot s belongs to port s
  for (genvar s = 0; s < CS; s++) begin : g_slot
    if (s < SERVED) begin : g_live
      usb_conn_view #(.LW(LW)) u_cc_view (
        .clk    (clk),
        .rst_n  (rst_n),
        .conn_i (xcvr_conn_i[s]),
        .line_i (xcvr_line_i[s*LW +: LW]),
        .mine_i (own[s]),
        .conn_o (cc_conn_o[s]),
        .csc_o  (cc_csc_o[s]),
        .line_o (cc_line_o[s*LW +: LW])
      );

      a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_conn_o[s] && cc_conn_o[s]));
    end else begin : g_dummy
      assign cc_conn_o[s]            = 1'b0;
      assign cc_csc_o[s]             = 1'b0;
      assign cc_line_o[s*LW +: LW]   = '0;
    end
  end

endmodule

// File: tb/usb_port_route_tb.sv
`timescale 1ns/100ps
module usb_port_route_tb;

  localparam int NP = 5;
  localparam int CS = 4;
  localparam int DW = 8;
  localparam int LW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst_n;
  logic                flag;
  logic [NP-1:0]       own_wr, own_wd;
  logic [NP*DW-1:0]    hs_tx;
  logic [CS*DW-1:0]    cc_tx;
  logic [NP-1:0]       conn;
  logic [NP*LW-1:0]    line;

  logic [NP-1:0]       owner, hs_conn, hs_csc;
  logic [NP*DW-1:0]    xtx;
  logic [NP*LW-1:0]    hs_line;
  logic [CS-1:0]       cc_conn, cc_csc;
  logic [CS*LW-1:0]    cc_line;

  logic [NP-1:0]       z_owner, z_hs_conn, z_hs_csc;
  logic [NP*DW-1:0]    z_xtx;
  logic [NP*LW-1:0]    z_hs_line;
  logic [0:0]          z_cc_conn, z_cc_csc;
  logic [LW-1:0]       z_cc_line;

  usb_port_route u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_flag_i(flag), .own_wr_i(own_wr), .own_wdata_i(own_wd),
    .owner_o(owner), .hs_tx_i(hs_tx), .cc_tx_i(cc_tx), .xcvr_tx_o(xtx),
    .xcvr_conn_i(conn), .xcvr_line_i(line), .hs_conn_o(hs_conn), .hs_csc_o(hs_csc),
    .hs_line_o(hs_line), .cc_conn_o(cc_conn), .cc_csc_o(cc_csc), .cc_line_o(cc_line)
  );

  usb_port_route #(.N_COMP(0)) u_dut0 (
    .clk(clk), .rst_n(rst_n), .cfg_flag_i(flag), .own_wr_i(own_wr), .own_wdata_i(own_wd),
    .owner_o(z_owner), .hs_tx_i(hs_tx), .cc_tx_i(cc_tx[DW-1:0]), .xcvr_tx_o(z_xtx),
    .xcvr_conn_i(conn), .xcvr_line_i(line), .hs_conn_o(z_hs_conn), .hs_csc_o(z_hs_csc),
    .hs_line_o(z_hs_line), .cc_conn_o(z_cc_conn), .cc_csc_o(z_cc_csc), .cc_line_o(z_cc_line)
  );

  typedef enum int {S_OWN, S_HCONN, S_CCONN, S_HCSC, S_CCSC, S_HLINE, S_CLINE, S_TX,
                    S_Z_OWN, S_Z_HCONN, S_Z_TX} sel_t;
  typedef struct { sel_t sel; logic [63:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected transmit vector: owner 1 on a port with a companion picks cc slot
  function automatic logic [63:0] tx_exp(input logic [NP-1:0] o);
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++)
      v[p*DW +: DW] = (o[p] && p < CS) ? cc_tx[p*DW +: DW] : hs_tx[p*DW +: DW];
    return v;
  endfunction

  function automatic logic [63:0] line_exp(input logic [NP-1:0] m);
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++)
      if (m[p]) v[p*LW +: LW] = line[p*LW +: LW];
    return v;
  endfunction

  function automatic logic [63:0] actual(input sel_t s);
    case (s)
      S_OWN:     return 64'(owner);
      S_HCONN:   return 64'(hs_conn);
      S_CCONN:   return 64'(cc_conn);
      S_HCSC:    return 64'(hs_csc);
      S_CCSC:    return 64'(cc_csc);
      S_HLINE:   return 64'(hs_line);
      S_CLINE:   return 64'(cc_line);
      S_TX:      return 64'(xtx);
      S_Z_OWN:   return 64'(z_owner);
      S_Z_HCONN: return 64'(z_hs_conn);
      default:   return 64'(z_xtx);
    endcase
  endfunction

  task automatic push(input sel_t s, input logic [63:0] e, input string tag);
    item_t it;
    it.sel = s; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: compares queued expectations just after each rising edge
  always begin
    @(posedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (actual(it.sel) !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, actual(it.sel), it.exp);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flag = 0; own_wr = '0; own_wd = '0; conn = '0;
    for (int p = 0; p < NP; p++) begin
      hs_tx[p*DW +: DW] = 8'hA0 + 8'(p);
      line[p*LW +: LW]  = 2'((p % 3) + 1);
    end
    for (int s = 0; s < CS; s++) cc_tx[s*DW +: DW] = 8'hC0 + 8'(s);
    tick(); tick(); tick();
    // R1 reset state
    push(S_OWN, 64'h0F, "R1 reset owner");
    push(S_HCONN, 64'h0, "R1 reset hs conn");
    push(S_CCONN, 64'h0, "R1 reset cc conn");
    push(S_Z_OWN, 64'h0, "R9 reset owner no comp");
    tick();
    // release, ports 0,1,4 connected
    rst_n = 1; conn = 5'b10011;
    push(S_OWN, 64'h0F, "R1 owner after release");
    push(S_TX, tx_exp(5'b01111), "R5 tx companion owned");
    push(S_CCONN, 64'h3, "R6 cc conn");
    push(S_HCONN, 64'h10, "R6 hs conn unserved port");
    push(S_CCSC, 64'h3, "R8 cc change pulse");
    push(S_HCSC, 64'h10, "R8 hs change pulse");
    push(S_CLINE, line_exp(5'b01111), "R7 cc line");
    push(S_HLINE, line_exp(5'b10000), "R7 hs line");
    push(S_Z_HCONN, 64'h13, "R9 no comp hs conn");
    push(S_Z_TX, tx_exp(5'b00000), "R9 no comp tx");
    tick();
    // writes while flag clear
    own_wr = '1; own_wd = '0;
    push(S_OWN, 64'h0F, "R2 write ignored flag clear");
    push(S_CCSC, 64'h0, "R8 pulse one cycle");
    push(S_CCONN, 64'h3, "R6 cc conn held");
    tick();
    own_wr = '0; flag = 1;
    push(S_OWN, 64'h00, "R3 rise clears owners");
    push(S_TX, tx_exp(5'b00000), "R5 tx hs owned");
    push(S_CCONN, 64'h3, "R6 view lags owner");
    tick();
    push(S_HCONN, 64'h13, "R6 hs conn after handover");
    push(S_CCONN, 64'h0, "R6 cc conn after handover");
    push(S_HCSC, 64'h03, "R8 new owner connect pulse");
    push(S_CCSC, 64'h3, "R8 old owner disconnect pulse");
    push(S_HLINE, line_exp(5'b11111), "R7 hs line all");
    push(S_CLINE, 64'h0, "R7 cc line dark");
    tick();
    push(S_HCSC, 64'h0, "R8 hs pulse ends");
    push(S_CCSC, 64'h0, "R8 cc pulse ends");
    tick();
    // give ports 0,3,4 to companions; port 4 has none
    own_wr = 5'b11001; own_wd = '1;
    push(S_OWN, 64'h09, "R4 write ports 0 3, unserved 4 stays hs");
    push(S_TX, tx_exp(5'b01001), "R5 tx mixed");
    push(S_Z_OWN, 64'h0, "R9 no comp write ignored");
    tick();
    own_wr = '0;
    push(S_HCONN, 64'h12, "R6 hs loses port0");
    push(S_CCONN, 64'h1, "R6 cc gains port0");
    push(S_HCSC, 64'h01, "R8 hs disconnect pulse");
    push(S_CCSC, 64'h1, "R8 cc connect pulse");
    tick();
    conn = 5'b11011;
    push(S_CCONN, 64'h9, "R6 cc sees port3 connect");
    push(S_CCSC, 64'h8, "R8 cc port3 pulse");
    push(S_HCSC, 64'h0, "R8 hs no pulse");
    push(S_HLINE, line_exp(5'b10110), "R7 hs line mixed");
    push(S_CLINE, line_exp(5'b01001), "R7 cc line mixed");
    tick();
    flag = 0;
    push(S_OWN, 64'h0F, "R10 fall returns to companions");
    tick();
    push(S_CCONN, 64'hB, "R10 cc conn after fall");
    push(S_HCONN, 64'h10, "R10 hs conn after fall");
    tick();
    flag = 1; own_wr = 5'b00010; own_wd = '1;
    push(S_OWN, 64'h00, "R3 rise beats write");
    tick();
    own_wr = '0;
    tick(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule